// File: doc/BRIEF.md
# Gate-Drive Fault Protection Sequencer

This block is the digital supervisor for one power-switch gate driver. It takes an on/off command, a desaturation comparator flag, a comparator flag that reports the gate as near its off rail, and a digital code for the output supply voltage. From these it sets the controls of the output stage: a source enable, a sink enable (both may be off, leaving the output floating), a soft-shutdown enable and a Miller clamp enable. It also drives two active-low status flags, one for a latched fault and one for supply lockout.

A desaturation event sensed while the switch is driven on, past its turn-on blanking window and with the supply healthy, latches a fault. The hard drive is released and the gate discharges slowly through the soft-shutdown path. The command is then ignored for a mute interval. After that interval the command must stay low for an unbroken reset interval before normal drive resumes. Supply lockout applies hysteresis between a falling and a rising threshold and holds the gate low at power-up. All intervals are parameters in clock cycles. The three single-bit inputs pass through two-flop synchronizers; the supply code is taken as a synchronous value.

Top module: `gate_prot_seq`

## Requirements
- R1: With no fault latched and the supply out of lockout, a high command asserts only `src_en` and a low command asserts only `snk_en`; the output is never inverted; `src_en` and `snk_en` are never high together, and both are low while `rst_n` is low.
- R2: The desaturation input has no effect while the switch is commanded off: `fault_n` stays 1 and `snk_en` stays 1.
- R3: After each turn-on, desaturation is ignored for BLANK_INT+BLANK_EXT cycles: a command and a desaturation flag that rise on the same cycle latch the fault on the 11th rising edge after they are applied (2 synchronizer edges plus 8 blanking edges plus 1 detection edge with the values 3 and 5).
- R4: On detection `fault_n` goes to 0, `src_en` and `snk_en` both go to 0 and `ssd_en` goes to 1, three rising edges after the desaturation input rises on an armed switch.
- R5: For MUTE_CYC cycles from detection the command has no effect: a high command leaves `src_en` at 0 and `fault_n` at 0.
- R6: After the mute interval the command must be low for RESET_CYC consecutive synchronized cycles before the fault clears; any high command restarts that count, and low cycles during the mute interval do not count.
- R7: When the fault clears, `fault_n` returns to 1, `ssd_en` to 0, and the output again follows the command.
- R8: Lockout starts when the supply code is strictly below UV_FALL and ends only when it is strictly above UV_RISE; codes equal to a threshold change nothing; `uvlo_n` is 0 during lockout and `src_en` is then 0 with `snk_en` 1.
- R9: Out of reset the block is in lockout (`uvlo_n` = 0) and the gate is held low until the supply code exceeds UV_RISE.
- R10: Desaturation is sensed only out of lockout, and the blanking window restarts when lockout ends; a fault latched on the same edge that lockout begins keeps the output floating with soft shutdown while `uvlo_n` reports the lockout.
- R11: `clamp_en` is 1 exactly when `snk_en` is 1 and the synchronized gate-low flag is 1; it is 0 during a fault.
- R12: The command, desaturation and gate-low inputs each pass through two synchronizer flops before they act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Gate on/off command, high means on |
| desat_in | input | 1 | Desaturation comparator flag |
| gate_low_in | input | 1 | Gate-below-clamp-threshold comparator flag |
| vsup_code | input | VCODE_W | Output supply voltage code |
| src_en | output | 1 | Enable of the pull-up (source) path |
| snk_en | output | 1 | Enable of the pull-down (sink) path |
| ssd_en | output | 1 | Soft-shutdown discharge enable |
| clamp_en | output | 1 | Miller clamp enable |
| fault_n | output | 1 | Latched desaturation fault, active low |
| uvlo_n | output | 1 | Supply lockout, active low |

## Verification
Desaturation detection and entry into lockout can land on the same clock edge. The desaturation flag crosses two synchronizer flops and the supply code only one register. The bench therefore lowers the code two cycles after raising the flag, so that both take effect on one edge. It then expects the fault latched, the output floating with soft shutdown, and `uvlo_n` low in that same cycle. A second pass holds desaturation high through lockout and requires no fault until a full blanking window has run after the supply recovers.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_MUTE = 2'd1,
    PH_WAIT = 2'd2
  } prot_phase_t;
endpackage

// File: rtl/gps_sync.sv
module gps_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] shift_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-2:0], d[i]};
    end
    assign q[i] = shift_q[STAGES-1];
  end
endmodule

// File: rtl/gps_uvlo.sv
module gps_uvlo #(
  parameter int VCODE_W = 8,
  parameter int UV_FALL = 113,
  parameter int UV_RISE = 124
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VCODE_W-1:0] vsup_code,
  output logic               supply_ok
);
  localparam logic [VCODE_W-1:0] FALL_C = VCODE_W'(UV_FALL);
  localparam logic [VCODE_W-1:0] RISE_C = VCODE_W'(UV_RISE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_ok <= 1'b0;
    end else if (supply_ok) begin
      if (vsup_code < FALL_C) supply_ok <= 1'b0;
    end else begin
      if (vsup_code > RISE_C) supply_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/gps_fault.sv
module gps_fault
  import gps_pkg::*;
#(
  parameter int BLANK_INT = 150,
  parameter int BLANK_EXT = 200,
  parameter int MUTE_CYC  = 800000,
  parameter int RESET_CYC = 800000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_s,
  input  logic        desat_s,
  input  logic        supply_ok,
  output prot_phase_t phase
);
  localparam int BLANK_TOT = BLANK_INT + BLANK_EXT;
  localparam int BLK_W     = $clog2(BLANK_TOT + 1);
  localparam int TMAX      = (MUTE_CYC > RESET_CYC) ? MUTE_CYC : RESET_CYC;
  localparam int TMR_W     = $clog2(TMAX + 1);
  localparam logic [BLK_W-1:0] BLK_END  = BLK_W'(BLANK_TOT);
  localparam logic [TMR_W-1:0] MUTE_END = TMR_W'(MUTE_CYC - 1);
  localparam logic [TMR_W-1:0] RST_END  = TMR_W'(RESET_CYC - 1);

  logic [BLK_W-1:0] on_cnt;
  logic [TMR_W-1:0] tmr;
  logic             drive_on;
  logic             sense;

  assign drive_on = cmd_s && supply_ok && (phase == PH_RUN);
  assign sense    = drive_on && (on_cnt == BLK_END) && desat_s;

  // blanking window: counts cycles of actual on-drive, restarts on every turn-on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               on_cnt <= '0;
    else if (!drive_on)       on_cnt <= '0;
    else if (on_cnt != BLK_END) on_cnt <= on_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RUN;
      tmr   <= '0;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (sense) begin
            phase <= PH_MUTE;
            tmr   <= '0;
          end
        end
        PH_MUTE: begin
          if (tmr == MUTE_END) begin
            phase <= PH_WAIT;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_WAIT: begin
          if (cmd_s) begin
            tmr <= '0;
          end else if (tmr == RST_END) begin
            phase <= PH_RUN;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          phase <= PH_RUN;
          tmr   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
  import gps_pkg::*;
#(
  parameter int VCODE_W     = 8,
  parameter int UV_FALL     = 113,
  parameter int UV_RISE     = 124,
  parameter int BLANK_INT   = 150,
  parameter int BLANK_EXT   = 200,
  parameter int MUTE_CYC    = 800000,
  parameter int RESET_CYC   = 800000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_in,
  input  logic               desat_in,
  input  logic               gate_low_in,
  input  logic [VCODE_W-1:0] vsup_code,
  output logic               src_en,
  output logic               snk_en,
  output logic               ssd_en,
  output logic               clamp_en,
  output logic               fault_n,
  output logic               uvlo_n
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] syn_in;
  logic              cmd_s, desat_s, glow_s;
  logic              supply_ok;
  logic              live_q;
  prot_phase_t       phase;

  assign raw_in = {gate_low_in, desat_in, cmd_in};
  assign {glow_s, desat_s, cmd_s} = syn_in;

  gps_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  gps_uvlo #(.VCODE_W(VCODE_W), .UV_FALL(UV_FALL), .UV_RISE(UV_RISE)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .vsup_code(vsup_code), .supply_ok(supply_ok)
  );

  gps_fault #(
    .BLANK_INT(BLANK_INT), .BLANK_EXT(BLANK_EXT),
    .MUTE_CYC(MUTE_CYC), .RESET_CYC(RESET_CYC)
  ) u_fault (
    .clk(clk), .rst_n(rst_n), .cmd_s(cmd_s), .desat_s(desat_s),
    .supply_ok(supply_ok), .phase(phase)
  );

  // keeps both drive paths off through reset and its first cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    src_en = 1'b0;
    snk_en = 1'b0;
    ssd_en = 1'b0;
    if (live_q) begin
      if (phase != PH_RUN)          ssd_en = 1'b1;
      else if (supply_ok && cmd_s)  src_en = 1'b1;
      else                          snk_en = 1'b1;
    end
  end

  assign clamp_en = snk_en && glow_s;
  assign fault_n  = (phase == PH_RUN);
  assign uvlo_n   = supply_ok;
endmodule

// File: rtl/gate_prot_seq_chk.sv
module gate_prot_seq_chk #(
  parameter int VCODE_W = 8,
  parameter int UV_FALL = 113,
  parameter int UV_RISE = 124
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VCODE_W-1:0] vsup_code,
  input logic               src_en,
  input logic               snk_en,
  input logic               ssd_en,
  input logic               clamp_en,
  input logic               fault_n,
  input logic               uvlo_n
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en && snk_en));

  a_r4_float_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (!src_en && !snk_en && ssd_en));

  a_r2_fault_only_from_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(src_en));

  a_r5_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |=> !fault_n);

  a_r8_lock_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_n |-> !src_en);

  a_r8_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uvlo_n) |-> ($past(vsup_code) < VCODE_W'(UV_FALL)));

  a_r9_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uvlo_n) |-> ($past(vsup_code) > VCODE_W'(UV_RISE)));

  a_r11_clamp_with_sink: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> snk_en);
endmodule

bind gate_prot_seq gate_prot_seq_chk #(
  .VCODE_W(VCODE_W), .UV_FALL(UV_FALL), .UV_RISE(UV_RISE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vsup_code(vsup_code),
  .src_en(src_en), .snk_en(snk_en), .ssd_en(ssd_en),
  .clamp_en(clamp_en), .fault_n(fault_n), .uvlo_n(uvlo_n)
);

// File: tb/tb_gate_prot_seq.sv
`timescale 1ns/1ps
module tb_gate_prot_seq;
  localparam int MUTE = 40;
  localparam int RST  = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_in = 1'b0, desat_in = 1'b0, gate_low_in = 1'b0;
  logic [7:0] vsup_code = 8'd0;
  logic       src_en, snk_en, ssd_en, clamp_en, fault_n, uvlo_n;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  gate_prot_seq #(
    .VCODE_W(8), .UV_FALL(113), .UV_RISE(124),
    .BLANK_INT(3), .BLANK_EXT(5), .MUTE_CYC(MUTE), .RESET_CYC(RST),
    .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .desat_in(desat_in),
    .gate_low_in(gate_low_in), .vsup_code(vsup_code),
    .src_en(src_en), .snk_en(snk_en), .ssd_en(ssd_en),
    .clamp_en(clamp_en), .fault_n(fault_n), .uvlo_n(uvlo_n)
  );

  // outputs packed {src, snk, ssd, clamp, fault_n, uvlo_n}
  function automatic logic [5:0] outs();
    return {src_en, snk_en, ssd_en, clamp_en, fault_n, uvlo_n};
  endfunction

  task automatic chk(input string tag, input logic [5:0] got,
                     input logic [5:0] exp, input logic [5:0] mask);
    checks++;
    if ((got & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: got %b expected %b (mask %b) at %0t", tag, got, exp, mask, $time);
    end
  endtask

  // {cmd, desat, glow, vcode, exp outs}
  localparam logic [16:0] VEC [10] = '{
    {3'b000, 8'd100, 6'b010010},
    {3'b101, 8'd120, 6'b010110},
    {3'b001, 8'd130, 6'b010111},
    {3'b011, 8'd130, 6'b010111},
    {3'b110, 8'd130, 6'b100011},
    {3'b100, 8'd120, 6'b100011},
    {3'b100, 8'd110, 6'b010010},
    {3'b101, 8'd118, 6'b010110},
    {3'b000, 8'd125, 6'b010011},
    {3'b100, 8'd125, 6'b100011}
  };

  localparam logic [5:0] ALL   = 6'b111111;
  localparam logic [5:0] M_FLT = 6'b000010;
  localparam logic [5:0] M_UV  = 6'b000001;
  localparam logic [5:0] M_SRC = 6'b100000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 R9 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset drive off", outs(), 6'b000010, ALL);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 power-up locked, sink on", outs(), 6'b010010, ALL);

    // table walk: R1 R2 R8 R9 R11 R12
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {cmd_in, desat_in, gate_low_in} = VEC[i][16:14];
      vsup_code = VEC[i][13:6];
      repeat (5) @(posedge clk); #1;
      chk($sformatf("R1/R2/R8/R11 vector %0d", i), outs(), VEC[i][5:0], ALL);
    end

    // R3: blanking boundary, cmd and desat raised together
    @(negedge clk); cmd_in = 0; desat_in = 0; gate_low_in = 0; vsup_code = 8'd130;
    repeat (6) @(posedge clk);
    @(negedge clk); cmd_in = 1; desat_in = 1;
    @(posedge clk); #1;
    chk("R12 cmd not yet through synchronizer", outs(), 6'b010011, ALL);
    repeat (9) @(posedge clk); #1;
    chk("R3 still blanked at edge 10", outs(), 6'b100011, ALL);
    @(posedge clk); #1;
    chk("R3 R4 fault latched at edge 11", outs(), 6'b001001, ALL);

    // R5 mute, R6 count starts after mute, R7 R11 clear
    @(negedge clk); cmd_in = 0; desat_in = 0; gate_low_in = 1;
    repeat (10) @(posedge clk);
    @(negedge clk); cmd_in = 1;
    repeat (4) @(posedge clk); #1;
    chk("R5 command ignored in mute, R11 no clamp", outs(), 6'b001001, ALL);
    @(negedge clk); cmd_in = 0;
    repeat (55) @(posedge clk); #1;
    chk("R6 fault held one cycle before clear", outs(), 6'b001001, ALL);
    @(posedge clk); #1;
    chk("R7 R11 fault cleared, sink and clamp", outs(), 6'b010111, ALL);
    @(negedge clk); cmd_in = 1; gate_low_in = 0;
    repeat (2) @(posedge clk); #1;
    chk("R7 output follows command again", outs(), 6'b100011, ALL);

    // R6 high command restarts the reset count
    repeat (12) @(posedge clk);
    @(negedge clk); desat_in = 1;
    repeat (2) @(posedge clk); #1;
    chk("R12 desat not yet through synchronizer", outs(), 6'b100011, ALL);
    @(posedge clk); #1;
    chk("R4 fault three edges after desat", outs(), 6'b001001, ALL);
    @(negedge clk); desat_in = 0;
    repeat (100) @(posedge clk); #1;
    chk("R6 high command keeps fault", outs(), 6'b001001, ALL);
    @(negedge clk); cmd_in = 0;
    repeat (15) @(posedge clk);
    @(negedge clk); cmd_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); cmd_in = 0;
    repeat (15) @(posedge clk); #1;
    chk("R6 pulse restarted count", outs(), 6'b001001, M_FLT);
    repeat (16) @(posedge clk); #1;
    chk("R6 fault until restarted count ends", outs(), 6'b001001, M_FLT);
    @(posedge clk); #1;
    chk("R6 R7 clear after restarted count", outs(), 6'b010011, ALL);

    // R10 desat and lockout on the same edge
    @(negedge clk); cmd_in = 1; gate_low_in = 1;
    repeat (15) @(posedge clk);
    @(negedge clk); desat_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); vsup_code = 8'd100;
    @(posedge clk); #1;
    chk("R10 fault and lockout together", outs(), 6'b001000, ALL);
    @(negedge clk); desat_in = 0; cmd_in = 0; vsup_code = 8'd130;
    repeat (MUTE + RST + 10) @(posedge clk); #1;
    chk("R7 recovered after coincident event", outs(), 6'b010111, ALL);

    // R10 desat ignored in lockout, blanking restarts on release
    @(negedge clk); vsup_code = 8'd100; gate_low_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); cmd_in = 1; desat_in = 1;
    repeat (20) @(posedge clk); #1;
    chk("R10 desat ignored in lockout", outs(), 6'b010010, ALL);
    @(negedge clk); vsup_code = 8'd130;
    repeat (9) @(posedge clk); #1;
    chk("R10 blanking after lockout release", outs(), 6'b100011, ALL);
    @(posedge clk); #1;
    chk("R10 fault after fresh blanking", outs(), 6'b001001, ALL);

    // R8 thresholds are strict
    @(negedge clk); cmd_in = 0; desat_in = 0; vsup_code = 8'd113;
    repeat (3) @(posedge clk); #1;
    chk("R8 code at falling threshold keeps supply", outs(), 6'b000001, M_UV);
    @(negedge clk); vsup_code = 8'd112;
    repeat (3) @(posedge clk); #1;
    chk("R8 below falling threshold locks", outs(), 6'b000000, M_UV);
    @(negedge clk); vsup_code = 8'd124;
    repeat (3) @(posedge clk); #1;
    chk("R8 code at rising threshold stays locked", outs(), 6'b000000, M_UV);
    @(negedge clk); vsup_code = 8'd125;
    repeat (3) @(posedge clk); #1;
    chk("R8 above rising threshold releases", outs(), 6'b000001, M_UV);
    repeat (MUTE + RST + 10) @(posedge clk); #1;
    chk("R1 idle low command sinks", outs(), 6'b010011, ALL);
    @(negedge clk); cmd_in = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1 high command sources", outs(), 6'b100000, M_SRC);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule